// File: doc/BRIEF.md
# Interrupt Controller Indirect Register Window

This block is the register front end of a 24-pin I/O interrupt controller. Software reaches all of its state through two bus offsets. An 8-bit select register sits at offset 0x00 and a 32-bit data window sits at offset 0x10. The select value decides which internal word the window reads or writes. The words behind the window are an identifier word, a read-only version word, an arbitration word that mirrors the identifier, and one 64-bit routing entry per pin, reached as two 32-bit halves.

The whole routing table is driven out flat for the downstream delivery logic. Each accepted entry write raises a one-cycle rescan pulse. A write that flips an entry's mask bit raises a separate one-cycle pulse that carries the pin index and the new mask value. Two bits of each entry belong to hardware: the remote-request bit and the delivery-status bit. Downstream logic sets them through a status-update port. Bus writes never overwrite them. The block does not deliver interrupts itself.

Top module: `intc_regwin`

## Requirements
- R1: A bus write at offset 0x00 stores bus_wdata[7:0] in the select register and drops the upper bits. A read at offset 0x00 returns the stored select value, zero-extended.
- R2: With select 0x01, the window reads {8'h00, NUM_PINS-1, 8'h00, VER_CODE}. With defaults this is 0x00170011. Window writes at this select change nothing.
- R3: With select 0x00, a window write stores bus_wdata[27:24] as the 4-bit identifier. Reads at select 0x00 and at select 0x02 both return the identifier in bits 27:24, with all other bits zero. Window writes at select 0x02 change nothing.
- R4: For select values of 0x10 and above, the entry index is (select - 0x10) >> 1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0.
- R5: A window read returns 0xFFFFFFFF when the entry index is NUM_PINS or higher, and for select values 0x03 through 0x0F. A window write at any of these selects changes no state.
- R6: A window write to an entry leaves bit 12 (delivery status) and bit 14 (remote request) at their previous values.
- R7: After any window write to an entry, the remote-request bit is zero if the entry's bit 15 (trigger mode, 0 = edge, 1 = level) is 0.
- R8: After reset, the select register and identifier are zero, and every entry holds only bit 16 (mask) set. Both pulse outputs are low.
- R9: Reads at offsets other than 0x00 and 0x10 return zero. Writes at those offsets change no state.
- R10: tbl_flat[64*i +: 64] presents entry i. Its fields are: vector in 7:0, delivery mode in 10:8, destination mode in 11, delivery status in 12, polarity in 13, remote request in 14, trigger mode in 15, mask in 16, and destination in 63:56. Entry writes take effect on the next clock edge.
- R11: When a low-half entry write changes bit 16, mask_chg_vld is high for exactly the next cycle. During that cycle mask_chg_pin holds the entry index and mask_chg_state holds the new mask value. No other write raises it.
- R12: rescan_pulse is high for exactly one cycle after each window write that reaches a valid entry, and stays low otherwise.
- R13: A status update with st_pin below NUM_PINS loads st_remote_irr into bit 14 and st_dlv_status into bit 12 of that entry. A status update with a higher st_pin is ignored. If a window write to the same entry falls in the same cycle, the status values win over the preserved ones, and the R7 clear is then applied on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset within the block |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr in the same cycle |
| st_vld | input | 1 | Hardware status update strobe |
| st_pin | input | 5 | Entry index for the status update |
| st_remote_irr | input | 1 | New remote-request value |
| st_dlv_status | input | 1 | New delivery-status value |
| tbl_flat | output | 1536 | All routing entries, entry i at bits 64*i+63 : 64*i |
| mask_chg_vld | output | 1 | One-cycle pulse on a mask bit change |
| mask_chg_pin | output | 5 | Entry index of the mask change |
| mask_chg_state | output | 1 | Mask value after the change |
| rescan_pulse | output | 1 | One-cycle pulse after an accepted entry write |

## Verification
A bus write to an entry and a hardware status update to the same entry can land in the same clock cycle. That is where the ownership rules for the remote-request and delivery-status bits meet the edge-trigger clear. Directed steps make the two collide on level-mode and edge-mode entries. The random phase also pairs status updates with window writes, sometimes on the same pin. Every result is judged against a bench model that applies the status values first and then the edge clear. The model is compared with tbl_flat and with window read-back.

// File: rtl/intc_regwin_pkg.sv
package intc_regwin_pkg;
   localparam int ENT_W    = 64;
   localparam int HALF_W   = 32;
   localparam int SEL_W    = 8;
   localparam int ID_W     = 4;
   localparam int B_DLVS   = 12;
   localparam int B_RIRR   = 14;
   localparam int B_TRIG   = 15;
   localparam int B_MASK   = 16;
   localparam int B_ID_LSB = 24;

   localparam logic [SEL_W-1:0] SEL_ID       = 8'h00;
   localparam logic [SEL_W-1:0] SEL_VER      = 8'h01;
   localparam logic [SEL_W-1:0] SEL_ARB      = 8'h02;
   localparam logic [SEL_W-1:0] SEL_ENT_BASE = 8'h10;

   typedef enum logic [2:0] {
      TGT_ID,
      TGT_VER,
      TGT_ARB,
      TGT_ENT,
      TGT_VOID
   } tgt_e;
endpackage

// File: rtl/intc_regwin_decode.sv
module intc_regwin_decode
   import intc_regwin_pkg::*;
#(
   parameter int NUM_PINS = 24,
   parameter int PIN_W    = 5
) (
   input  logic [SEL_W-1:0] sel,
   output tgt_e             tgt,
   output logic [PIN_W-1:0] idx,
   output logic             hi
);
   localparam logic [SEL_W-2:0] NP_LIM = (SEL_W-1)'(NUM_PINS);

   logic [SEL_W-1:0] off;
   logic [SEL_W-2:0] raw;

   assign off = sel - SEL_ENT_BASE;
   assign raw = off[SEL_W-1:1];
   assign idx = raw[PIN_W-1:0];
   assign hi  = sel[0];

   always_comb begin
      case (sel)
         SEL_ID:  tgt = TGT_ID;
         SEL_VER: tgt = TGT_VER;
         SEL_ARB: tgt = TGT_ARB;
         default: begin
            if (sel >= SEL_ENT_BASE && raw < NP_LIM) tgt = TGT_ENT;
            else                                      tgt = TGT_VOID;
         end
      endcase
   end
endmodule

// File: rtl/intc_regwin_entry.sv
module intc_regwin_entry
   import intc_regwin_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] wdata,
   input  logic              st_upd,
   input  logic              st_rirr,
   input  logic              st_dlvs,
   output logic [ENT_W-1:0]  ent,
   output logic              mask_flip
);
   logic [ENT_W-1:0] nxt;
   logic             wr_any;

   assign wr_any    = wr_lo | wr_hi;
   assign mask_flip = wr_lo && (wdata[B_MASK] != ent[B_MASK]);

   always_comb begin
      nxt = ent;
      if (wr_lo) nxt[HALF_W-1:0]     = wdata;
      if (wr_hi) nxt[ENT_W-1:HALF_W] = wdata;
      nxt[B_DLVS] = st_upd ? st_dlvs : ent[B_DLVS];
      nxt[B_RIRR] = st_upd ? st_rirr : ent[B_RIRR];
      if (wr_any && !nxt[B_TRIG]) nxt[B_RIRR] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent <= ENT_W'(1) << B_MASK;
      else        ent <= nxt;
   end

   // R6: hardware-owned bits survive a bus write
   p_status_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && !st_upd) |=> (ent[B_DLVS] == $past(ent[B_DLVS])));

   // R7: an edge-mode entry never keeps remote request after a write
   p_edge_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_any |=> (ent[B_TRIG] || !ent[B_RIRR]));

   // R13: a lone status update lands in the entry
   p_status_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (st_upd && !wr_any) |=> (ent[B_DLVS] == $past(st_dlvs)));
endmodule

// File: rtl/intc_regwin_rdmux.sv
module intc_regwin_rdmux
   import intc_regwin_pkg::*;
#(
   parameter int           NUM_PINS = 24,
   parameter int           PIN_W    = 5,
   parameter logic [7:0]   VER_CODE = 8'h11
) (
   input  tgt_e                      tgt,
   input  logic [PIN_W-1:0]          idx,
   input  logic                      hi,
   input  logic [ID_W-1:0]           id,
   input  logic [NUM_PINS*ENT_W-1:0] tbl,
   output logic [HALF_W-1:0]         word
);
   localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

   logic [ENT_W-1:0] pick;

   always_comb begin
      pick = '1;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (idx == PIN_W'(i)) pick = tbl[i*ENT_W +: ENT_W];
      end
   end

   always_comb begin
      case (tgt)
         TGT_ID, TGT_ARB: word = HALF_W'(id) << B_ID_LSB;
         TGT_VER:         word = {8'h00, MAX_PIN, 8'h00, VER_CODE};
         TGT_ENT:         word = hi ? pick[ENT_W-1:HALF_W] : pick[HALF_W-1:0];
         default:         word = '1;
      endcase
   end
endmodule

// File: rtl/intc_regwin.sv
module intc_regwin
   import intc_regwin_pkg::*;
#(
   parameter int         NUM_PINS = 24,
   parameter int         PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
   parameter logic [7:0] VER_CODE = 8'h11,
   parameter logic [7:0] SEL_OFF  = 8'h00,
   parameter logic [7:0] WIN_OFF  = 8'h10,
   parameter bit         RDATA_REG = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [7:0]                bus_addr,
   input  logic                      bus_we,
   input  logic [HALF_W-1:0]         bus_wdata,
   output logic [HALF_W-1:0]         bus_rdata,
   input  logic                      st_vld,
   input  logic [PIN_W-1:0]          st_pin,
   input  logic                      st_remote_irr,
   input  logic                      st_dlv_status,
   output logic [NUM_PINS*ENT_W-1:0] tbl_flat,
   output logic                      mask_chg_vld,
   output logic [PIN_W-1:0]          mask_chg_pin,
   output logic                      mask_chg_state,
   output logic                      rescan_pulse
);
   generate
      if (NUM_PINS < 2 || NUM_PINS > 120) begin : g_bad_pins
         initial $fatal(1, "NUM_PINS must lie in 2..120");
      end
      if (PIN_W < $clog2(NUM_PINS) || PIN_W > 7) begin : g_bad_pinw
         initial $fatal(1, "PIN_W too narrow or too wide");
      end
      if (SEL_OFF == WIN_OFF) begin : g_bad_off
         initial $fatal(1, "select and window offsets must differ");
      end
   endgenerate

   logic [SEL_W-1:0]    sel_q;
   logic [ID_W-1:0]     id_q;
   tgt_e                tgt;
   logic [PIN_W-1:0]    ent_idx;
   logic                ent_hi;
   logic                hit_sel, hit_win, win_we, ent_we;
   logic [NUM_PINS-1:0] flip_v;
   logic [HALF_W-1:0]   win_word, rd_comb;

   assign hit_sel = (bus_addr == SEL_OFF);
   assign hit_win = (bus_addr == WIN_OFF);
   assign win_we  = bus_we && hit_win;
   assign ent_we  = win_we && (tgt == TGT_ENT);

   intc_regwin_decode #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_dec (
      .sel (sel_q),
      .tgt (tgt),
      .idx (ent_idx),
      .hi  (ent_hi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
      end else begin
         if (bus_we && hit_sel) sel_q <= bus_wdata[SEL_W-1:0];
         if (win_we && tgt == TGT_ID) id_q <= bus_wdata[B_ID_LSB +: ID_W];
      end
   end

   generate
      for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
         logic hit_pin, st_hit;
         assign hit_pin = ent_we && (ent_idx == PIN_W'(g));
         assign st_hit  = st_vld && (st_pin == PIN_W'(g));
         intc_regwin_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (hit_pin && !ent_hi),
            .wr_hi     (hit_pin && ent_hi),
            .wdata     (bus_wdata),
            .st_upd    (st_hit),
            .st_rirr   (st_remote_irr),
            .st_dlvs   (st_dlv_status),
            .ent       (tbl_flat[g*ENT_W +: ENT_W]),
            .mask_flip (flip_v[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rescan_pulse   <= 1'b0;
         mask_chg_vld   <= 1'b0;
         mask_chg_pin   <= '0;
         mask_chg_state <= 1'b0;
      end else begin
         rescan_pulse <= ent_we;
         mask_chg_vld <= |flip_v;
         if (|flip_v) begin
            mask_chg_pin   <= ent_idx;
            mask_chg_state <= bus_wdata[B_MASK];
         end
      end
   end

   intc_regwin_rdmux #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .VER_CODE(VER_CODE)) u_rd (
      .tgt  (tgt),
      .idx  (ent_idx),
      .hi   (ent_hi),
      .id   (id_q),
      .tbl  (tbl_flat),
      .word (win_word)
   );

   always_comb begin
      if (hit_sel)      rd_comb = HALF_W'(sel_q);
      else if (hit_win) rd_comb = win_word;
      else              rd_comb = '0;
   end

   generate
      if (RDATA_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bus_rdata <= '0;
            else        bus_rdata <= rd_comb;
         end
      end else begin : g_rd_comb
         assign bus_rdata = rd_comb;
      end
   endgenerate

   // R1: the select register keeps only the low byte
   p_sel_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_sel) |=> (sel_q == $past(bus_wdata[SEL_W-1:0])));

   // R5: a window write to an invalid selection leaves the table alone
   p_oob_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_we && tgt == TGT_VOID && !st_vld) |=> $stable(tbl_flat));

   // R9: writes at other offsets touch neither select nor identifier
   p_other_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !hit_sel && !hit_win) |=> ($stable(sel_q) && $stable(id_q)));

   // R11: a mask pulse only accompanies an accepted entry write
   p_mask_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mask_chg_vld |-> rescan_pulse);

   // R12: the rescan pulse lasts a single cycle per write
   p_rescan_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rescan_pulse && !$past(ent_we, 1)) |-> 1'b0);
endmodule

// File: tb/intc_regwin_bench.sv
module intc_regwin_bench;
   localparam int NP = 24;
   localparam int PW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          st_vld = 1'b0;
   logic [PW-1:0] st_pin = '0;
   logic          st_remote_irr = 1'b0;
   logic          st_dlv_status = 1'b0;
   logic [NP*64-1:0] tbl_flat;
   logic          mask_chg_vld;
   logic [PW-1:0] mask_chg_pin;
   logic          mask_chg_state;
   logic          rescan_pulse;

   int n_chk = 0;
   int n_fail = 0;

   logic [63:0] m_ent [NP];
   logic [7:0]  m_sel;
   logic [3:0]  m_id;

   always #10 clk = ~clk;

   intc_regwin u_intc_regwin (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .st_vld(st_vld),
      .st_pin(st_pin), .st_remote_irr(st_remote_irr), .st_dlv_status(st_dlv_status),
      .tbl_flat(tbl_flat), .mask_chg_vld(mask_chg_vld), .mask_chg_pin(mask_chg_pin),
      .mask_chg_state(mask_chg_state), .rescan_pulse(rescan_pulse)
   );

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_rd(logic [7:0] a);
      logic [6:0] ix;
      logic [7:0] off;
      if (a == 8'h00) return {24'h0, m_sel};
      if (a != 8'h10) return 32'h0;
      if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
      if (m_sel == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, 8'h11};
      if (m_sel < 8'h10) return 32'hFFFF_FFFF;
      off = m_sel - 8'h10;
      ix = off[7:1];
      if (ix >= 7'(NP)) return 32'hFFFF_FFFF;
      return m_sel[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
   endfunction

   task automatic chk_rd(logic [7:0] a, string req);
      bus_addr = a;
      bus_we = 1'b0;
      #1;
      check(req, 64'(bus_rdata), 64'(model_rd(a)));
   endtask

   task automatic chk_tbl(string req);
      logic ok = 1'b1;
      for (int i = 0; i < NP; i++) if (tbl_flat[i*64 +: 64] !== m_ent[i]) ok = 1'b0;
      n_chk++;
      if (!ok) begin
         n_fail++;
         for (int i = 0; i < NP; i++)
            if (tbl_flat[i*64 +: 64] !== m_ent[i])
               $display("FAIL %s: entry %0d actual %h expected %h", req, i,
                        tbl_flat[i*64 +: 64], m_ent[i]);
      end
   endtask

   // one cycle: optional bus write plus optional status update
   task automatic op(logic we, logic [7:0] a, logic [31:0] d,
                     logic sv, logic [PW-1:0] sp, logic sr, logic sd);
      logic       e_rescan = 1'b0, e_flip = 1'b0;
      logic [6:0] ix = '0;
      logic [7:0] off;
      logic [63:0] n;
      logic       stv;
      stv = sv && (int'(sp) < NP);
      if (stv) begin
         m_ent[sp][12] = sd;
         m_ent[sp][14] = sr;
      end
      if (we && a == 8'h00) m_sel = d[7:0];
      if (we && a == 8'h10) begin
         if (m_sel == 8'h00) m_id = d[27:24];
         else if (m_sel >= 8'h10) begin
            off = m_sel - 8'h10;
            ix = off[7:1];
            if (ix < 7'(NP)) begin
               e_rescan = 1'b1;
               n = m_ent[ix];
               if (m_sel[0]) n[63:32] = d;
               else begin
                  n[31:0] = d;
                  e_flip = (d[16] != m_ent[ix][16]);
               end
               n[12] = m_ent[ix][12];
               n[14] = m_ent[ix][14];
               if (!n[15]) n[14] = 1'b0;
               m_ent[ix] = n;
            end
         end
      end
      bus_addr = a; bus_we = we; bus_wdata = d;
      st_vld = sv; st_pin = sp; st_remote_irr = sr; st_dlv_status = sd;
      @(negedge clk);
      bus_we = 1'b0; st_vld = 1'b0;
      check("R12 rescan", 64'(rescan_pulse), 64'(e_rescan));
      check("R11 mask pulse", 64'(mask_chg_vld), 64'(e_flip));
      if (e_flip) begin
         check("R11 mask pin", 64'(mask_chg_pin), 64'(ix[PW-1:0]));
         check("R11 mask state", 64'(mask_chg_state), 64'(d[16]));
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      op(1'b1, a, d, 1'b0, '0, 1'b0, 1'b0);
   endtask

   task automatic idle();
      op(1'b0, 8'h00, 32'h0, 1'b0, '0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < NP; i++) m_ent[i] = 64'h1 << 16;
      m_sel = 8'h00; m_id = 4'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 reset state
      chk_tbl("R8 reset table");
      check("R8 reset rescan", 64'(rescan_pulse), 64'h0);
      check("R8 reset mask pulse", 64'(mask_chg_vld), 64'h0);
      chk_rd(8'h00, "R8 reset select");
      chk_rd(8'h10, "R8 reset id");

      // R1 select keeps low byte
      wr(8'h00, 32'hABCD_1234);
      chk_rd(8'h00, "R1 select byte");

      // R2 version read, writes ignored
      wr(8'h00, 32'h1);
      chk_rd(8'h10, "R2 version");
      wr(8'h10, 32'hFFFF_FFFF);
      chk_rd(8'h10, "R2 version after write");
      chk_tbl("R2 table untouched");

      // R3 identifier and arbitration mirror
      wr(8'h00, 32'h0);
      wr(8'h10, 32'hF9A5_5A5A);
      chk_rd(8'h10, "R3 id read");
      wr(8'h00, 32'h2);
      chk_rd(8'h10, "R3 arb mirror");
      wr(8'h10, 32'h0);
      chk_rd(8'h10, "R3 arb write ignored");

      // R4 and R10 index and half mapping
      wr(8'h00, 32'h10 + 2*5);
      wr(8'h10, 32'h0001_A7C5);
      wr(8'h00, 32'h10 + 2*5 + 1);
      wr(8'h10, 32'h9E00_0000);
      chk_rd(8'h10, "R4 upper half");
      wr(8'h00, 32'h10 + 2*5);
      chk_rd(8'h10, "R4 lower half");
      chk_tbl("R10 table layout");
      check("R10 vector field", 64'(tbl_flat[5*64 +: 8]), 64'hC5);
      check("R10 destination field", 64'(tbl_flat[5*64 + 56 +: 8]), 64'h9E);

      // R5 out of range
      wr(8'h00, 32'h10 + 2*NP);
      chk_rd(8'h10, "R5 beyond table read");
      wr(8'h10, 32'h0);
      chk_tbl("R5 beyond table write");
      wr(8'h00, 32'h05);
      chk_rd(8'h10, "R5 low gap read");
      wr(8'h10, 32'h0);
      chk_tbl("R5 low gap write");
      wr(8'h00, 32'hFF);
      chk_rd(8'h10, "R5 top select read");

      // R6 status preserved on level entry, R13 status load
      wr(8'h00, 32'h10 + 2*3);
      wr(8'h10, 32'h0000_8030);
      op(1'b0, 8'h00, 32'h0, 1'b1, 5'd3, 1'b1, 1'b1);
      chk_tbl("R13 status load");
      wr(8'h10, 32'h0000_8031);
      chk_rd(8'h10, "R6 status kept");
      check("R6 remote bit", 64'(tbl_flat[3*64 + 14]), 64'h1);
      // R7 switching to edge clears remote request
      wr(8'h10, 32'h0000_0031);
      check("R7 edge clear", 64'(tbl_flat[3*64 + 14]), 64'h0);
      check("R7 delivery status kept", 64'(tbl_flat[3*64 + 12]), 64'h1);

      // R13 collision on level entry and edge entry
      op(1'b1, 8'h10, 32'h0000_8032, 1'b1, 5'd3, 1'b1, 1'b0);
      chk_tbl("R13 collision level");
      op(1'b1, 8'h10, 32'h0000_0033, 1'b1, 5'd3, 1'b1, 1'b1);
      chk_tbl("R13 collision edge");
      op(1'b0, 8'h00, 32'h0, 1'b1, 5'd30, 1'b1, 1'b1);
      chk_tbl("R13 pin out of range");

      // R9 other offsets
      wr(8'h04, 32'h0000_0077);
      wr(8'h20, 32'hFFFF_FFFF);
      chk_rd(8'h00, "R9 select untouched");
      chk_rd(8'h08, "R9 other read zero");
      chk_tbl("R9 table untouched");

      // random phase
      for (int k = 0; k < 600; k++) begin
         int unsigned r = $urandom % 8;
         logic [31:0] d = $urandom;
         logic sv = ($urandom % 4) == 0;
         logic [PW-1:0] sp = PW'($urandom % 28);
         logic sr = d[5] ^ d[9];
         logic sd = d[3];
         if (r < 3) begin
            logic [7:0] s = (r == 2) ? d[7:0] : 8'($urandom % 8'h44);
            op(1'b1, 8'h00, {d[31:8], s}, sv, sp, sr, sd);
         end else if (r < 6) begin
            if (sv && (m_sel >= 8'h10) && (($urandom % 2) == 0))
               sp = PW'((m_sel - 8'h10) >> 1);
            op(1'b1, 8'h10, d, sv, sp, sr, sd);
         end else if (r == 6) begin
            op(1'b0, 8'h10, d, 1'b1, sp, sr, sd);
         end else begin
            op(1'b1, 8'($urandom % 256) | 8'h01, d, sv, sp, sr, sd);
         end
         chk_rd(8'h00, "R1 random select");
         chk_rd(8'h10, "R4 random window");
         chk_tbl("R13 random table");
      end
      idle();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule